// File: doc/BRIEF.md
# MDIO Management Frame Slave

This block sits on the management side of a PHY. It listens to a bit-banged management clock and data pair and decodes clause-22 style management frames from it. It collects a preamble of ones, then a start pattern, a two-bit opcode, a five-bit PHY address and a five-bit register address. After a two-period turnaround it either shifts sixteen bits of register data back to the station or captures sixteen bits from it. Both lines are brought into the system clock domain through synchronizer chains. Each edge of the management clock is then seen as a one-cycle pulse.

The register contents live outside the block, in an attached register model. For a read aimed at this slave's own PHY address, the block fetches the word through a combinational read port at the end of the turnaround. For a write, it issues one write strobe once the last data bit has been sampled. A frame addressed to any other PHY address gets the answer of an empty bus: the read data is all ones and no write is issued. The PHY address that the block answers to is a parameter.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: While reset is asserted, and right after it, `mdio_oe` and `mdio_out` are 0 and neither register strobe is active.
- R2: A start bit is accepted only on a rising MDC edge that samples MDIO low. At least 64 MDC edges must have been counted since the decoder last entered its preamble state, including that edge. A frame whose preamble is far shorter (10 periods) is ignored: no strobe and no drive.
- R3: The opcode (2 bits), the PHY address (5 bits) and the register address (5 bits) are shifted in MSB first on rising MDC edges. The captured register address appears on `reg_addr`.
- R4: A read (opcode binary 10) to the slave's own PHY address pulses `reg_rd_stb` once at the end of the turnaround. It then drives the fetched 16-bit word MSB first, changing `mdio_out` only after falling MDC edges, so that the station sees bit 15 down to bit 0 on the 16 rising edges that follow the turnaround.
- R5: `mdio_oe` stays low during both turnaround periods. It is high for all 16 data periods of a read and low again after the 16th data rising edge.
- R6: A write (opcode binary 01) to the slave's own PHY address samples 16 data bits MSB first on rising edges. It then issues exactly one `reg_wr_stb` pulse, carrying that word on `reg_wr_data` and the frame's register address on `reg_addr`.
- R7: A read to any other PHY address pulses no `reg_rd_stb` and still drives 0xFFFF.
- R8: A write to any other PHY address pulses no `reg_wr_stb`, and the addressed register keeps its value.
- R9: The opcodes binary 00 and 11 cause neither drive nor write.
- R10: After the 16th data bit the decoder is back in its preamble state, so frames sent one after another each decode correctly, each behind a fresh 32-period preamble.
- R11: The PHY address the slave answers to is set by the `PHY_ADDR` parameter, default 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples MDC and MDIO |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc_i | input | 1 | Management clock from the station |
| mdio_i | input | 1 | Management data as seen on the bus |
| mdio_out | output | 1 | Data bit driven by the slave during a read |
| mdio_oe | output | 1 | Drive enable for `mdio_out` |
| reg_addr | output | ADDR_W | Register address of the current or last frame |
| reg_rd_stb | output | 1 | One-cycle read fetch pulse at the end of turnaround |
| reg_rd_data | input | DATA_W | Register word returned for `reg_addr`, combinational |
| reg_wr_stb | output | 1 | One-cycle write commit pulse |
| reg_wr_data | output | DATA_W | Word to write, valid with `reg_wr_stb` |

## Verification
The assertions assume that each MDC half-period lasts several system clocks longer than the synchronizer latency, so that a rising and a falling edge never fall in the same cycle. They also assume that MDIO is steady across every rising MDC edge. The bench holds each MDC level for eight system clocks and changes MDIO only at the start of the low phase, well away from either edge. It reads `mdio_out` at the very end of each low phase, which is where a station would sample.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;

  typedef enum logic [2:0] {
    ST_PRE  = 3'd0,
    ST_SOF  = 3'd1,
    ST_OPC  = 3'd2,
    ST_PHY  = 3'd3,
    ST_REG  = 3'd4,
    ST_TA   = 3'd5,
    ST_DATA = 3'd6
  } mdio_state_e;

  localparam logic [1:0] OPC_RD = 2'b10;
  localparam logic [1:0] OPC_WR = 2'b01;

endpackage

// File: rtl/mdio_line_sync.sv
module mdio_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc_i,
  input  logic mdio_i,
  output logic mdio_s,
  output logic mdc_rise,
  output logic mdc_fall
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] synced;
  logic              mdc_d;

  assign raw = {mdio_i, mdc_i};

  // one synchronizer chain per incoming line
  for (genvar g = 0; g < NLINES; g++) begin : g_chain
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdc_d <= 1'b0;
    else        mdc_d <= synced[0];
  end

  assign mdio_s   = synced[1];
  assign mdc_rise =  synced[0] & ~mdc_d;
  assign mdc_fall = ~synced[0] &  mdc_d;

endmodule

// File: rtl/mdio_frame_decoder.sv
module mdio_frame_decoder
  import mdio_slave_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int PRE_EDGES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc_rise,
  input  logic              mdc_fall,
  input  logic              mdio_s,
  output mdio_state_e       state_o,
  output logic [1:0]        opc_o,
  output logic [ADDR_W-1:0] phy_o,
  output logic [ADDR_W-1:0] reg_o,
  output logic              ta_done,
  output logic              data_done
);

  localparam int CNT_LIM = (PRE_EDGES > 2*DATA_W) ? PRE_EDGES : 2*DATA_W;
  localparam int CNT_W   = $clog2(CNT_LIM + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] E_PRE   = CNT_W'(PRE_EDGES);
  localparam logic [CNT_W-1:0] E_SOF   = CNT_W'(2);
  localparam logic [CNT_W-1:0] E_OPC   = CNT_W'(4);
  localparam logic [CNT_W-1:0] E_ADR   = CNT_W'(2*ADDR_W);
  localparam logic [CNT_W-1:0] E_TA    = CNT_W'(4);
  localparam logic [CNT_W-1:0] E_DAT   = CNT_W'(2*DATA_W);

  mdio_state_e       st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;
  logic [1:0]        opc_q, opc_d;
  logic [ADDR_W-1:0] phy_q, phy_d;
  logic [ADDR_W-1:0] reg_q, reg_d;

  // next-state logic: every MDC edge advances the counter (saturating)
  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    opc_d     = opc_q;
    phy_d     = phy_q;
    reg_d     = reg_q;
    ta_done   = 1'b0;
    data_done = 1'b0;
    cnt_inc   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    if (mdc_rise || mdc_fall) cnt_d = cnt_inc;

    case (st_q)
      ST_PRE: begin
        if (mdc_rise && (cnt_inc >= E_PRE) && !mdio_s) begin
          st_d  = ST_SOF;
          cnt_d = '0;
        end
      end
      ST_SOF: begin
        if (mdc_rise && (cnt_inc == E_SOF)) begin
          st_d  = ST_OPC;
          cnt_d = '0;
          opc_d = '0;
        end
      end
      ST_OPC: begin
        if (mdc_rise) begin
          opc_d = {opc_q[0], mdio_s};
          if (cnt_inc == E_OPC) begin
            st_d  = ST_PHY;
            cnt_d = '0;
            phy_d = '0;
          end
        end
      end
      ST_PHY: begin
        if (mdc_rise) begin
          phy_d = {phy_q[ADDR_W-2:0], mdio_s};
          if (cnt_inc == E_ADR) begin
            st_d  = ST_REG;
            cnt_d = '0;
            reg_d = '0;
          end
        end
      end
      ST_REG: begin
        if (mdc_rise) begin
          reg_d = {reg_q[ADDR_W-2:0], mdio_s};
          if (cnt_inc == E_ADR) begin
            st_d  = ST_TA;
            cnt_d = '0;
          end
        end
      end
      ST_TA: begin
        if (mdc_rise && (cnt_inc == E_TA)) begin
          st_d    = ST_DATA;
          cnt_d   = '0;
          ta_done = 1'b1;
        end
      end
      ST_DATA: begin
        if (mdc_rise && (cnt_inc == E_DAT)) begin
          st_d      = ST_PRE;
          cnt_d     = '0;
          data_done = 1'b1;
        end
      end
      default: begin
        st_d  = ST_PRE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_PRE;
      cnt_q <= '0;
      opc_q <= '0;
      phy_q <= '0;
      reg_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      opc_q <= opc_d;
      phy_q <= phy_d;
      reg_q <= reg_d;
    end
  end

  assign state_o = st_q;
  assign opc_o   = opc_q;
  assign phy_o   = phy_q;
  assign reg_o   = reg_q;

  // R2: the start bit is taken only once the preamble edge count is reached
  a_r2_preamble_long_enough: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SOF && $past(st_q) == ST_PRE) |-> ($past(cnt_q) >= E_PRE - 1'b1));

  // R3: the PHY address field spans exactly ADDR_W clock periods
  a_r3_phy_field_len: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REG && $past(st_q) == ST_PHY) |-> ($past(cnt_q) == E_ADR - 1'b1));

  // R10: after the data phase the decoder goes back to the preamble
  a_r10_back_to_preamble: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA && mdc_rise && cnt_q == E_DAT - 1'b1) |=> (st_q == ST_PRE));

endmodule

// File: rtl/mdio_data_path.sv
module mdio_data_path #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc_rise,
  input  logic              mdc_fall,
  input  logic              mdio_s,
  input  logic              in_data,
  input  logic              ta_done,
  input  logic              data_done,
  input  logic              load_rd,
  input  logic [DATA_W-1:0] load_val,
  input  logic              commit_ok,
  output logic              out_o,
  output logic              oe_o,
  output logic              wr_stb_o,
  output logic [DATA_W-1:0] wr_data_o
);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic              drive_q, drive_d;
  logic              out_q, out_d;
  logic              wr_q, wr_d;

  always_comb begin
    sh_d    = sh_q;
    drive_d = drive_q;
    out_d   = out_q;
    wr_d    = 1'b0;
    if (ta_done) begin
      drive_d = load_rd;
      out_d   = 1'b0;
      sh_d    = load_rd ? load_val : '0;
    end else if (in_data) begin
      if (drive_q && mdc_fall) begin
        out_d = sh_q[DATA_W-1];
        sh_d  = {sh_q[DATA_W-2:0], 1'b0};
      end
      if (!drive_q && mdc_rise) begin
        sh_d = {sh_q[DATA_W-2:0], mdio_s};
      end
      if (data_done) begin
        wr_d    = !drive_q && commit_ok;
        drive_d = 1'b0;
        out_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      drive_q <= 1'b0;
      out_q   <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      drive_q <= drive_d;
      out_q   <= out_d;
      wr_q    <= wr_d;
    end
  end

  assign out_o     = out_q;
  assign oe_o      = drive_q;
  assign wr_stb_o  = wr_q;
  assign wr_data_o = sh_q;

  // R5: the line is driven only while the decoder is in its data phase
  a_r5_drive_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    drive_q |-> in_data);

  // R4: while driving, the data bit changes only after a falling MDC edge
  a_r4_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_q && $past(drive_q) && !$past(mdc_fall)) |-> $stable(out_q));

  // R6: a write commit is a single-cycle pulse
  a_r6_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> !wr_q);

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_slave_pkg::*;
#(
  parameter int PHY_ADDR    = 1,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16,
  parameter int PRE_EDGES   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc_i,
  input  logic              mdio_i,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_rd_stb,
  input  logic [DATA_W-1:0] reg_rd_data,
  output logic              reg_wr_stb,
  output logic [DATA_W-1:0] reg_wr_data
);

  localparam logic [ADDR_W-1:0] PHY_LOC = ADDR_W'(PHY_ADDR);

  // reset asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic              mdio_s, mdc_rise, mdc_fall;
  mdio_state_e       state;
  logic [1:0]        opc;
  logic [ADDR_W-1:0] phy_field, reg_field;
  logic              ta_done, data_done;
  logic              phy_hit, is_read, in_data;
  logic [DATA_W-1:0] load_val;

  mdio_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .mdc_i    (mdc_i),
    .mdio_i   (mdio_i),
    .mdio_s   (mdio_s),
    .mdc_rise (mdc_rise),
    .mdc_fall (mdc_fall)
  );

  mdio_frame_decoder #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PRE_EDGES (PRE_EDGES)
  ) u_dec (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .mdc_rise  (mdc_rise),
    .mdc_fall  (mdc_fall),
    .mdio_s    (mdio_s),
    .state_o   (state),
    .opc_o     (opc),
    .phy_o     (phy_field),
    .reg_o     (reg_field),
    .ta_done   (ta_done),
    .data_done (data_done)
  );

  assign phy_hit  = (phy_field == PHY_LOC);
  assign is_read  = (opc == OPC_RD);
  assign in_data  = (state == ST_DATA);
  // an absent device reads as an idle, pulled-up bus
  assign load_val = phy_hit ? reg_rd_data : '1;

  mdio_data_path #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .mdc_rise  (mdc_rise),
    .mdc_fall  (mdc_fall),
    .mdio_s    (mdio_s),
    .in_data   (in_data),
    .ta_done   (ta_done),
    .data_done (data_done),
    .load_rd   (is_read),
    .load_val  (load_val),
    .commit_ok (phy_hit && (opc == OPC_WR)),
    .out_o     (mdio_out),
    .oe_o      (mdio_oe),
    .wr_stb_o  (reg_wr_stb),
    .wr_data_o (reg_wr_data)
  );

  assign reg_addr   = reg_field;
  assign reg_rd_stb = ta_done && is_read && phy_hit;

  // R7/R8: no register access for a frame aimed at another PHY address
  a_r7_absent_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    (phy_field != PHY_LOC) |-> !(reg_rd_stb || reg_wr_stb));

  // R6: a write commit always lands back in the preamble state
  a_r6_commit_in_preamble: assert property (@(posedge clk) disable iff (!rst_int_n)
    reg_wr_stb |-> (state == ST_PRE && !mdio_oe));

endmodule

// File: tb/tb_mdio_mgmt_slave.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_slave;

  localparam int H = 8;  // system clocks per MDC half period

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdc_i = 1'b0;
  logic        mdio_i = 1'b1;
  logic        mdio_out, mdio_oe;
  logic [4:0]  reg_addr;
  logic        reg_rd_stb, reg_wr_stb;
  logic [15:0] reg_rd_data, reg_wr_data;

  logic [15:0] model [32];
  int rd_cnt = 0, wr_cnt = 0;
  logic [4:0]  last_wr_addr, last_rd_addr;
  logic [15:0] last_wr_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mdio_mgmt_slave dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .mdc_i       (mdc_i),
    .mdio_i      (mdio_i),
    .mdio_out    (mdio_out),
    .mdio_oe     (mdio_oe),
    .reg_addr    (reg_addr),
    .reg_rd_stb  (reg_rd_stb),
    .reg_rd_data (reg_rd_data),
    .reg_wr_stb  (reg_wr_stb),
    .reg_wr_data (reg_wr_data)
  );

  assign reg_rd_data = model[reg_addr];

  // register model and strobe monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (reg_wr_stb) begin
      model[reg_addr] <= reg_wr_data;
      wr_cnt <= wr_cnt + 1;
      last_wr_addr <= reg_addr;
      last_wr_data <= reg_wr_data;
    end
    if (reg_rd_stb) begin
      rd_cnt <= rd_cnt + 1;
      last_rd_addr <= reg_addr;
    end
  end

  task automatic check(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mdc_period(input logic b, output logic s_out, output logic s_oe);
    mdio_i = b;
    repeat (H) @(negedge clk);
    s_out = mdio_out;
    s_oe  = mdio_oe;
    mdc_i = 1'b1;
    repeat (H) @(negedge clk);
    mdc_i = 1'b0;
  endtask

  // one management frame; returns the read word and drive observations
  task automatic frame(input int npre, input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] rg, input logic [15:0] wd,
                       output logic [15:0] rd, output bit oe_ta, output bit oe_all,
                       output bit oe_any);
    logic so, se;
    oe_ta = 0; oe_all = 1; oe_any = 0; rd = '0;
    for (int i = 0; i < npre; i++) begin mdc_period(1'b1, so, se); oe_any |= se; end
    mdc_period(1'b0, so, se); oe_any |= se;
    mdc_period(1'b1, so, se); oe_any |= se;
    for (int i = 1; i >= 0; i--) begin mdc_period(op[i], so, se); oe_any |= se; end
    for (int i = 4; i >= 0; i--) begin mdc_period(phy[i], so, se); oe_any |= se; end
    for (int i = 4; i >= 0; i--) begin mdc_period(rg[i], so, se); oe_any |= se; end
    mdc_period(1'b1, so, se); oe_ta |= se;
    mdc_period((op == 2'b10) ? 1'b1 : 1'b0, so, se); oe_ta |= se;
    for (int i = 15; i >= 0; i--) begin
      mdc_period((op == 2'b10) ? 1'b1 : wd[i], so, se);
      rd[i] = so; oe_all &= se; oe_any |= se;
    end
    mdio_i = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 oe after reset", mdio_oe === 1'b0, mdio_oe, 0);
    check("R1 out after reset", mdio_out === 1'b0, mdio_out, 0);
    check("R1 strobes after reset", {reg_rd_stb, reg_wr_stb} === 2'b00, {reg_rd_stb, reg_wr_stb}, 0);
  endtask

  task automatic t_write_own();
    logic [15:0] rd; bit ta, all, any; int w0 = wr_cnt;
    frame(32, 2'b01, 5'd1, 5'd5, 16'hA5C3, rd, ta, all, any);
    check("R6 one write strobe", wr_cnt == w0 + 1, wr_cnt, w0 + 1);
    check("R6 write data", last_wr_data == 16'hA5C3, last_wr_data, 16'hA5C3);
    check("R3 write register address", last_wr_addr == 5'd5, last_wr_addr, 5);
    check("R11 default PHY address 1 answered", model[5] == 16'hA5C3, model[5], 16'hA5C3);
    check("R5 no drive on write", !any && !ta, any, 0);
  endtask

  task automatic t_read_own(input logic [4:0] rg, input logic [15:0] exp, input string tag);
    logic [15:0] rd; bit ta, all, any; int r0 = rd_cnt;
    frame(32, 2'b10, 5'd1, rg, 16'h0, rd, ta, all, any);
    check({tag, " R4 read data"}, rd == exp, rd, exp);
    check({tag, " R4 one read strobe"}, rd_cnt == r0 + 1, rd_cnt, r0 + 1);
    check({tag, " R3 read register address"}, last_rd_addr == rg, last_rd_addr, rg);
    check({tag, " R5 oe low in turnaround"}, !ta, ta, 0);
    check({tag, " R5 oe high for all data"}, all, all, 1);
    check({tag, " R5 oe low after frame"}, mdio_oe === 1'b0, mdio_oe, 0);
  endtask

  task automatic t_read_absent();
    logic [15:0] rd; bit ta, all, any; int r0 = rd_cnt;
    frame(32, 2'b10, 5'd2, 5'd5, 16'h0, rd, ta, all, any);
    check("R7 absent read all ones", rd == 16'hFFFF, rd, 16'hFFFF);
    check("R7 absent read no strobe", rd_cnt == r0, rd_cnt, r0);
  endtask

  task automatic t_write_absent();
    logic [15:0] rd; bit ta, all, any; int w0 = wr_cnt;
    frame(32, 2'b01, 5'd17, 5'd5, 16'h1234, rd, ta, all, any);
    check("R8 absent write no strobe", wr_cnt == w0, wr_cnt, w0);
    t_read_own(5'd5, 16'hA5C3, "R8 reg kept");
  endtask

  task automatic t_odd_opcodes();
    logic [15:0] rd; bit ta, all, any; int w0 = wr_cnt; int r0 = rd_cnt;
    logic [15:0] keep = model[7];
    frame(32, 2'b11, 5'd1, 5'd7, 16'h0000, rd, ta, all, any);
    check("R9 opcode 11 no drive", !any && !ta, any, 0);
    frame(32, 2'b00, 5'd1, 5'd7, 16'h0000, rd, ta, all, any);
    check("R9 opcode 00 no drive", !any && !ta, any, 0);
    check("R9 no write strobe", wr_cnt == w0, wr_cnt, w0);
    check("R9 no read strobe", rd_cnt == r0, rd_cnt, r0);
    t_read_own(5'd7, keep, "R9 reg kept");
  endtask

  task automatic t_short_preamble();
    logic [15:0] rd; bit ta, all, any; int w0 = wr_cnt; int r0 = rd_cnt;
    frame(10, 2'b10, 5'd1, 5'd0, 16'h0, rd, ta, all, any);
    check("R2 short preamble no drive", !any && !ta, any, 0);
    check("R2 short preamble no strobe", (rd_cnt == r0) && (wr_cnt == w0), rd_cnt, r0);
    t_read_own(5'd18, model[18], "R2 recovery");
  endtask

  task automatic t_back_to_back();
    logic [15:0] rd; bit ta, all, any;
    frame(32, 2'b01, 5'd1, 5'd31, 16'h5A0F, rd, ta, all, any);
    check("R10 first write", model[31] == 16'h5A0F, model[31], 16'h5A0F);
    frame(32, 2'b10, 5'd1, 5'd31, 16'h0, rd, ta, all, any);
    check("R10 following read", rd == 16'h5A0F, rd, 16'h5A0F);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 16'h1000 + 16'(i) * 16'h0101;
    model[18] = 16'h3C0F;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_own();
    t_read_own(5'd5, 16'hA5C3, "R4 first");
    t_read_own(5'd18, 16'h3C0F, "R3 second pattern");
    t_read_absent();
    t_write_absent();
    t_odd_opcodes();
    t_short_preamble();
    t_back_to_back();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule